// File: doc/BRIEF.md
# Secure Loader Command Gate

This block sits behind the serial receiver of a secure boot loader. It takes single-byte ASCII commands, one per valid cycle, and decodes each one into a command strobe. It checks every command that reads or writes the encrypted external memory against the current state of the security lock. It does not parse hex records, compute CRCs or move memory data. Its only jobs are to sequence and gate commands.

The block also manages the session key. A session-start pulse arms a one-time key commit. The first memory command that is allowed after that pulse raises a strobe that moves the pending random 64-bit key into the live key register. Later memory commands in the same session leave the key untouched, so dump, verify and CRC see plaintext. A command that the lock refuses raises an access-denied pulse instead of a strobe. Bytes outside the accepted command set raise an invalid-command pulse.

Top module: `ldr_cmd_gate`

## Requirements
- R1: After reset, every output is 0. This covers all strobes, deny, invalid, both lock requests and key commit.
- R2: A valid byte from the accepted set produces exactly one strobe bit in `cmd_stb`, in the cycle after the byte is sampled, for one cycle only. Bit indices are: 'C'=0, 'D'=1, 'F'=2, 'G'=3, 'L'=4, 'N'=5, 'P'=6, 'R'=7, 'T'=8, 'U'=9, 'V'=10, 'W'=11, 'Z'=12. Matching is case-sensitive.
- R3: Any other valid byte, lowercase letters included, raises `bad_cmd` for one cycle in the cycle after sampling. It gives no strobe and no deny.
- R4: While `byte_vld` is low, `byte_data` has no effect, and no output pulses in the following cycle.
- R5: The memory commands are C, D, F, L and V. If one arrives while `lock_set` is 1, the block raises `access_deny` for one cycle and gives no strobe and no key commit.
- R6: 'U' raises `lock_clr_req` and 'Z' raises `lock_set_req`, each together with its strobe, whatever the lock state.
- R7: The first memory command allowed after a session-start pulse raises `key_commit` in the same cycle as its strobe.
- R8: Within one session, no further memory command raises `key_commit`.
- R9: A new `sess_start` pulse re-arms the commit. A byte sampled in the same cycle as `sess_start` belongs to the new session.
- R10: After reset and before the first `sess_start`, memory commands never raise `key_commit`.
- R11: A denied memory command does not use up the armed commit. The next allowed memory command in that session still commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sess_start | input | 1 | One-cycle pulse marking a new loader session |
| byte_vld | input | 1 | Received byte is valid this cycle |
| byte_data | input | 8 | Received command byte (ASCII) |
| lock_set | input | 1 | Current security lock state, 1 = locked |
| cmd_stb | output | 13 | One-hot command strobe, bit order per R2 |
| access_deny | output | 1 | Memory command refused by the lock |
| bad_cmd | output | 1 | Byte not in the accepted command set |
| lock_set_req | output | 1 | Request to set the security lock |
| lock_clr_req | output | 1 | Request to clear the security lock |
| key_commit | output | 1 | Load the pending random key into the live key |

## Verification
The assertions check these properties on every cycle:
- the strobe vector stays one-hot or empty;
- any pulse follows a valid byte;
- no memory strobe follows a cycle in which the lock was set;
- deny and invalid never coincide with a strobe;
- a key commit rides on a memory strobe;
- at most one commit happens between session-start pulses.

Other behaviour can only be shown by the directed scenarios:
- the exact bit mapped to each letter;
- that the first permitted command really does commit;
- that a denied command leaves the commit armed;
- that a byte arriving together with the session-start pulse counts in the new session.

// File: rtl/ldr_cmd_pkg.sv
package ldr_cmd_pkg;

  localparam int NCMD = 13;

  typedef enum logic [3:0] {
    CI_C = 4'd0, CI_D = 4'd1, CI_F = 4'd2, CI_G = 4'd3, CI_L = 4'd4,
    CI_N = 4'd5, CI_P = 4'd6, CI_R = 4'd7, CI_T = 4'd8, CI_U = 4'd9,
    CI_V = 4'd10, CI_W = 4'd11, CI_Z = 4'd12
  } cmd_idx_e;

  // Commands that reach the encrypted memory and load the session key.
  localparam logic [NCMD-1:0] MEM_MASK =
    (NCMD'(1) << CI_C) | (NCMD'(1) << CI_D) | (NCMD'(1) << CI_F) |
    (NCMD'(1) << CI_L) | (NCMD'(1) << CI_V);

  function automatic logic [7:0] code_of(input int idx);
    case (idx)
      0:  code_of = "C";
      1:  code_of = "D";
      2:  code_of = "F";
      3:  code_of = "G";
      4:  code_of = "L";
      5:  code_of = "N";
      6:  code_of = "P";
      7:  code_of = "R";
      8:  code_of = "T";
      9:  code_of = "U";
      10: code_of = "V";
      11: code_of = "W";
      default: code_of = "Z";
    endcase
  endfunction

endpackage

// File: rtl/ldr_cmd_decode.sv
module ldr_cmd_decode
  import ldr_cmd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic [BYTE_W-1:0] byte_data,
  output logic [NCMD-1:0]   hit,
  output logic              known,
  output logic              mem_hit
);

  for (genvar gi = 0; gi < NCMD; gi++) begin : g_match
    assign hit[gi] = (byte_data == BYTE_W'(code_of(gi)));
  end

  assign known   = |hit;
  assign mem_hit = |(hit & MEM_MASK);

endmodule

// File: rtl/ldr_key_arm.sv
module ldr_key_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic sess_start,
  input  logic consume,
  output logic armed_eff
);

  logic armed_q;
  logic armed_d;

  assign armed_eff = armed_q | sess_start;

  always_comb begin
    armed_d = armed_eff;
    if (consume) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

endmodule

// File: rtl/ldr_pulse_reg.sv
module ldr_pulse_reg #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

endmodule

// File: rtl/ldr_cmd_gate.sv
module ldr_cmd_gate
  import ldr_cmd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_start,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              lock_set,
  output logic [NCMD-1:0]   cmd_stb,
  output logic              access_deny,
  output logic              bad_cmd,
  output logic              lock_set_req,
  output logic              lock_clr_req,
  output logic              key_commit
);

  localparam int OUT_W = NCMD + 5;

  logic [NCMD-1:0] hit;
  logic            known;
  logic            mem_hit;
  logic            armed_eff;
  logic            consume;

  logic [NCMD-1:0] stb_d;
  logic            deny_d, bad_d, set_d, clr_d, commit_d;
  logic [OUT_W-1:0] out_d, out_q;

  ldr_cmd_decode #(.BYTE_W(BYTE_W)) u_dec (
    .byte_data (byte_data),
    .hit       (hit),
    .known     (known),
    .mem_hit   (mem_hit)
  );

  // Commit only when a memory command is allowed through in an armed session.
  assign consume = byte_vld & mem_hit & ~lock_set & armed_eff;

  ldr_key_arm u_arm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sess_start (sess_start),
    .consume    (consume),
    .armed_eff  (armed_eff)
  );

  always_comb begin
    stb_d    = '0;
    deny_d   = 1'b0;
    bad_d    = 1'b0;
    set_d    = 1'b0;
    clr_d    = 1'b0;
    commit_d = 1'b0;
    if (byte_vld) begin
      bad_d = ~known;
      if (mem_hit && lock_set) begin
        deny_d = 1'b1;
      end else begin
        stb_d    = hit;
        commit_d = consume;
      end
      set_d = hit[CI_Z];
      clr_d = hit[CI_U];
    end
  end

  assign out_d = {stb_d, deny_d, bad_d, set_d, clr_d, commit_d};

  ldr_pulse_reg #(.W(OUT_W)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (out_d),
    .q     (out_q)
  );

  assign {cmd_stb, access_deny, bad_cmd, lock_set_req, lock_clr_req, key_commit} = out_q;

endmodule

// File: rtl/ldr_cmd_gate_chk.sv
module ldr_cmd_gate_chk
  import ldr_cmd_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            sess_start,
  input logic            byte_vld,
  input logic            lock_set,
  input logic [NCMD-1:0] cmd_stb,
  input logic            access_deny,
  input logic            bad_cmd,
  input logic            lock_set_req,
  input logic            lock_clr_req,
  input logic            key_commit
);

  logic committed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          committed_q <= 1'b0;
    else if (sess_start) committed_q <= 1'b0;
    else if (key_commit) committed_q <= 1'b1;
  end

  assert_stb_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_stb));

  assert_pulse_needs_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((|cmd_stb) || access_deny || bad_cmd || lock_set_req || lock_clr_req || key_commit)
      |-> $past(byte_vld));

  assert_bad_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |-> (cmd_stb == '0) && !access_deny);

  assert_deny_no_stb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    access_deny |-> ((cmd_stb & MEM_MASK) == '0) && !key_commit);

  assert_mem_needs_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(cmd_stb & MEM_MASK)) |-> !$past(lock_set));

  assert_commit_on_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    key_commit |-> (|(cmd_stb & MEM_MASK)));

  assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    key_commit |-> !committed_q);

endmodule

bind ldr_cmd_gate ldr_cmd_gate_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sess_start   (sess_start),
  .byte_vld     (byte_vld),
  .lock_set     (lock_set),
  .cmd_stb      (cmd_stb),
  .access_deny  (access_deny),
  .bad_cmd      (bad_cmd),
  .lock_set_req (lock_set_req),
  .lock_clr_req (lock_clr_req),
  .key_commit   (key_commit)
);

// File: tb/test_ldr_cmd_gate.sv
module test_ldr_cmd_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sess_start = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic        lock_set = 1'b0;
  logic [12:0] cmd_stb;
  logic        access_deny, bad_cmd, lock_set_req, lock_clr_req, key_commit;

  int total = 0;
  int bad = 0;

  // Captured outputs: {stb, deny, bad, set, clr, commit}
  logic [17:0] got;

  localparam logic [7:0] LETTERS [13] =
    '{"C","D","F","G","L","N","P","R","T","U","V","W","Z"};

  always #5 clk = ~clk;

  ldr_cmd_gate i_ldr_cmd_gate (
    .clk(clk), .rst_n(rst_n), .sess_start(sess_start), .byte_vld(byte_vld),
    .byte_data(byte_data), .lock_set(lock_set), .cmd_stb(cmd_stb),
    .access_deny(access_deny), .bad_cmd(bad_cmd), .lock_set_req(lock_set_req),
    .lock_clr_req(lock_clr_req), .key_commit(key_commit)
  );

  function automatic logic [17:0] pack_out();
    return {cmd_stb, access_deny, bad_cmd, lock_set_req, lock_clr_req, key_commit};
  endfunction

  function automatic logic [17:0] exp_out(input logic [12:0] s, input logic d,
      input logic b, input logic zs, input logic uc, input logic k);
    return {s, d, b, zs, uc, k};
  endfunction

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs, then capture outputs a cycle later at negedge.
  task automatic xfer(input logic [7:0] b, input logic v, input logic s);
    @(negedge clk);
    byte_vld = v; byte_data = b; sess_start = s;
    @(negedge clk);
    byte_vld = 1'b0; sess_start = 1'b0; byte_data = 8'h00;
    got = pack_out();
  endtask

  task automatic t_reset();
    check("R1", pack_out(), '0);
    xfer(8'h00, 1'b0, 1'b0);
    check("R1", got, '0);
  endtask

  task automatic t_decode();
    for (int i = 0; i < 13; i++) begin
      xfer(LETTERS[i], 1'b1, 1'b0);
      check("R2", got, exp_out(13'(1) << i, 1'b0, 1'b0, i == 12, i == 9, 1'b0));
      @(negedge clk);
      check("R2", pack_out(), '0);
    end
  endtask

  task automatic t_invalid();
    logic [7:0] junk [5] = '{"A", "c", "z", 8'h00, 8'hFF};
    for (int i = 0; i < 5; i++) begin
      xfer(junk[i], 1'b1, 1'b0);
      check("R3", got, exp_out('0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0));
    end
  endtask

  task automatic t_idle();
    xfer("D", 1'b0, 1'b1);
    check("R4", got, '0);
    xfer("Z", 1'b0, 1'b0);
    check("R4", got, '0);
    // the session started above must still be armed
    xfer("F", 1'b1, 1'b0);
    check("R7", got, exp_out(13'h004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_session();
    xfer("L", 1'b1, 1'b1);
    check("R9", got, exp_out(13'h010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
    xfer("D", 1'b1, 1'b0);
    check("R8", got, exp_out(13'h002, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    xfer("V", 1'b1, 1'b0);
    check("R8", got, exp_out(13'h400, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    xfer("G", 1'b0, 1'b1);
    xfer("C", 1'b1, 1'b0);
    check("R9", got, exp_out(13'h001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_locked();
    xfer(8'h00, 1'b0, 1'b1);
    lock_set = 1'b1;
    xfer("D", 1'b1, 1'b0);
    check("R5", got, exp_out('0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    xfer("C", 1'b1, 1'b0);
    check("R5", got, exp_out('0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0));
    xfer("R", 1'b1, 1'b0);
    check("R5", got, exp_out(13'h080, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    xfer("Z", 1'b1, 1'b0);
    check("R6", got, exp_out(13'h1000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0));
    xfer("U", 1'b1, 1'b0);
    check("R6", got, exp_out(13'h200, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0));
    lock_set = 1'b0;
    xfer("F", 1'b1, 1'b0);
    check("R11", got, exp_out(13'h004, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1));
  endtask

  task automatic t_no_session();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    xfer("L", 1'b1, 1'b0);
    check("R10", got, exp_out(13'h010, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
    xfer("D", 1'b1, 1'b0);
    check("R10", got, exp_out(13'h002, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_decode();
    t_invalid();
    t_idle();
    t_session();
    t_locked();
    t_no_session();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule